// File: doc/BRIEF.md
# Cache Line Status and Lock Array

This block keeps the per-line bookkeeping for a write-through, set-associative cache. Every line has three status bits: valid, instruction-locked and data-locked. Because every store is written through, no line can be dirty and no modified state exists. The tag RAM, the data RAM and the bus side are outside the block. An external tag compare tells the block whether a request hit and in which way.

Each cycle the block accepts one request: a status read, a fill, a lock-set or a lock-clear. Requests are fully pipelined and can follow each other back to back. For each fill the block decides whether the line may be allocated. That decision depends on the access class, the configured allocation policy, an I/O stash window, a stash transaction flag and a global lock. The block then picks a victim way by round-robin among the unlocked ways of the set.

A line whose fill address falls inside either of two lock windows is locked as it is allocated. Two pulse inputs flash-clear all instruction locks or all data locks in a single clock.

Top module: `line_status_array`

## Requirements
- R1: After synchronous reset every line is invalid with both lock bits clear, `rsp_valid` is 0, and the round-robin start of every set is way 0.
- R2: A request with `req_op` 1 (read), 2 (fill), 3 (lock-set) or 4 (lock-clear) produces `rsp_valid`=1 exactly one cycle later, and `req_op` 0 produces `rsp_valid`=0. A request sees the updates of the request in the cycle before it.
- R3: The response fields `rsp_v`, `rsp_il` and `rsp_dl` give the status of the targeted line after the operation. For a read, the target is way `req_way` of the set in `req_addr` bits [OFF_W+IDX_W-1:OFF_W], and `rsp_way` echoes `req_way`.
- R4: `cfg_policy` 0 lets only instruction fills (`req_class` 0) allocate, 1 lets only data fills (`req_class` 1) allocate, 2 lets both allocate, and 3 lets neither allocate.
- R5: An I/O write fill (`req_class` 2) allocates, whatever the policy, when `req_stash`=1 or when `req_addr` lies in [`cfg_io_base`, `cfg_io_limit`] inclusive. Otherwise it is dropped.
- R6: The victim is the first way with both lock bits clear, scanning upward with wrap-around from the set's round-robin start. After an allocation the start becomes victim+1 modulo WAYS, and each set keeps its own start.
- R7: When every way of the set is locked, a fill is dropped: `rsp_alloc`=0, `rsp_way`=0, the status outputs are 0 and no line changes.
- R8: When a fill allocates and its address lies inside an enabled lock window (`cfg_lk_en[k]`, bounds inclusive), the new line is valid. An instruction fill gets the instruction lock, a data or I/O fill gets the data lock, and the other lock bit is clear.
- R9: Lock-set (3) and lock-clear (4) with `req_hit`=1 set or clear the instruction lock for class 0 and the data lock for other classes on way `req_way`. With `req_hit`=0 they change nothing.
- R10: While `cfg_lock_all`=1 no fill allocates and no line is replaced.
- R11: A pulse on `flash_clr_ilock` clears every instruction lock bit in one clock and leaves the valid and data lock bits unchanged. A pulse on `flash_clr_dlock` does the same for the data lock bits.
- R12: A read in the same cycle as a flash-clear returns the state before the clear. A lock-set in the same cycle as a flash-clear is applied after the clear on its own line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | 0 none, 1 read, 2 fill, 3 lock-set, 4 lock-clear |
| req_class | input | 2 | 0 instruction, 1 data, 2 I/O write |
| req_stash | input | 1 | Stash transaction type on an I/O write |
| req_addr | input | ADDR_W | Line address of the request |
| req_hit | input | 1 | Tag compare hit for lock commands |
| req_way | input | WAY_W | Target way for read and lock commands |
| cfg_policy | input | 2 | Allocation policy |
| cfg_io_base | input | ADDR_W | Stash window lower bound |
| cfg_io_limit | input | ADDR_W | Stash window upper bound |
| cfg_lk_en | input | NLK | Lock window enables |
| cfg_lk_base | input | NLK*ADDR_W | Lock window lower bounds, window k in slice k |
| cfg_lk_limit | input | NLK*ADDR_W | Lock window upper bounds, window k in slice k |
| cfg_lock_all | input | 1 | Global whole-cache lock |
| flash_clr_ilock | input | 1 | Clear all instruction locks |
| flash_clr_dlock | input | 1 | Clear all data locks |
| rsp_valid | output | 1 | Response present |
| rsp_alloc | output | 1 | Fill allocated |
| rsp_way | output | WAY_W | Victim way or echoed way |
| rsp_v | output | 1 | Line valid after the operation |
| rsp_il | output | 1 | Line instruction lock after the operation |
| rsp_dl | output | 1 | Line data lock after the operation |

## Verification
The assertions assume the following about the block's inputs:
- The external tag logic raises `req_hit` only for a valid line.
- Fills are issued only on misses.
- `req_class` never takes the unused value 3.
- The configuration inputs do not change in the same cycle as a request they would affect.

The stimulus keeps to these rules. It changes the policy, the global lock and the windows only between requests, with idle cycles around each change. It targets lock commands with a hit only at lines that earlier fills made valid. It drives the class with the three defined codes only.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_READ = 3'd1,
        OP_FILL = 3'd2,
        OP_LSET = 3'd3,
        OP_LCLR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CL_INSTR = 2'd0,
        CL_DATA  = 2'd1,
        CL_IOWR  = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        POL_INSTR = 2'd0,
        POL_DATA  = 2'd1,
        POL_BOTH  = 2'd2,
        POL_NONE  = 2'd3
    } pol_e;

    typedef struct packed {
        logic v;
        logic il;
        logic dl;
    } line_st_t;

    function automatic logic policy_permits(pol_e p, cls_e c);
        case (c)
            CL_INSTR: return (p == POL_INSTR) || (p == POL_BOTH);
            CL_DATA:  return (p == POL_DATA)  || (p == POL_BOTH);
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic is_known_op(op_e o);
        return (o == OP_READ) || (o == OP_FILL) || (o == OP_LSET) || (o == OP_LCLR);
    endfunction

endpackage

// File: rtl/lsa_alloc_ctl.sv
module lsa_alloc_ctl
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NLK    = 2
) (
    input  cls_e                    cls,
    input  logic                    stash,
    input  logic [ADDR_W-1:0]       addr,
    input  pol_e                    policy,
    input  logic [ADDR_W-1:0]       io_base,
    input  logic [ADDR_W-1:0]       io_limit,
    input  logic [NLK-1:0]          lk_en,
    input  logic [NLK*ADDR_W-1:0]   lk_base,
    input  logic [NLK*ADDR_W-1:0]   lk_limit,
    input  logic                    lock_all,
    output logic                    want_alloc,
    output logic                    auto_il,
    output logic                    auto_dl
);
    logic [NLK-1:0] win_hit;
    logic           io_hit;
    logic           in_lock_win;

    for (genvar k = 0; k < NLK; k++) begin : g_win
        logic [ADDR_W-1:0] lo, hi;
        assign lo = lk_base[k*ADDR_W +: ADDR_W];
        assign hi = lk_limit[k*ADDR_W +: ADDR_W];
        assign win_hit[k] = lk_en[k] && (addr >= lo) && (addr <= hi);
    end

    assign io_hit      = (addr >= io_base) && (addr <= io_limit);
    assign in_lock_win = |win_hit;

    always_comb begin
        if (lock_all)
            want_alloc = 1'b0;
        else if (cls == CL_IOWR)
            want_alloc = stash || io_hit;
        else
            want_alloc = policy_permits(policy, cls);
    end

    assign auto_il = in_lock_win && (cls == CL_INSTR);
    assign auto_dl = in_lock_win && (cls != CL_INSTR);

endmodule

// File: rtl/lsa_victim_rr.sv
module lsa_victim_rr #(
    parameter  int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  locked,
    input  logic [WAY_W-1:0] start,
    output logic             found,
    output logic [WAY_W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < WAYS; k++) begin
            int j;
            j = (int'(start) + k) % WAYS;
            if (!found && !locked[j]) begin
                found = 1'b1;
                pick  = WAY_W'(j);
            end
        end
    end

endmodule

// File: rtl/lsa_status_mem.sv
module lsa_status_mem
    import lsa_pkg::*;
#(
    parameter  int SETS  = 16,
    parameter  int WAYS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             we,
    input  logic [WAY_W-1:0] wway,
    input  line_st_t         wdata,
    input  logic             ptr_we,
    input  logic [WAY_W-1:0] ptr_nxt,
    input  logic             clr_il,
    input  logic             clr_dl,
    output line_st_t         rd_lines [WAYS],
    output logic [WAY_W-1:0] rd_ptr
);
    line_st_t         lines [SETS][WAYS];
    logic [WAY_W-1:0] rr_ptr [SETS];
    logic             il_any, dl_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                rr_ptr[s] <= '0;
                for (int w = 0; w < WAYS; w++)
                    lines[s][w] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    if (clr_il) lines[s][w].il <= 1'b0;
                    if (clr_dl) lines[s][w].dl <= 1'b0;
                end
            if (we)
                lines[set_idx][wway] <= wdata;
            if (ptr_we)
                rr_ptr[set_idx] <= ptr_nxt;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++)
            rd_lines[w] = lines[set_idx][w];
    end
    assign rd_ptr = rr_ptr[set_idx];

    always_comb begin
        il_any = 1'b0;
        dl_any = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                il_any = il_any | lines[s][w].il;
                dl_any = dl_any | lines[s][w].dl;
            end
    end

    // R11
    ilock_flash_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_il && !(we && wdata.il)) |=> !il_any);

    // R11
    dlock_flash_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_dl && !(we && wdata.dl)) |=> !dl_any);

endmodule

// File: rtl/line_status_array.sv
module line_status_array
    import lsa_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int SETS       = 16,
    parameter  int WAYS       = 4,
    parameter  int LINE_BYTES = 32,
    parameter  int NLK        = 2,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int IDX_W      = $clog2(SETS),
    localparam int OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            req_op,
    input  logic [1:0]            req_class,
    input  logic                  req_stash,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_hit,
    input  logic [WAY_W-1:0]      req_way,
    input  logic [1:0]            cfg_policy,
    input  logic [ADDR_W-1:0]     cfg_io_base,
    input  logic [ADDR_W-1:0]     cfg_io_limit,
    input  logic [NLK-1:0]        cfg_lk_en,
    input  logic [NLK*ADDR_W-1:0] cfg_lk_base,
    input  logic [NLK*ADDR_W-1:0] cfg_lk_limit,
    input  logic                  cfg_lock_all,
    input  logic                  flash_clr_ilock,
    input  logic                  flash_clr_dlock,
    output logic                  rsp_valid,
    output logic                  rsp_alloc,
    output logic [WAY_W-1:0]      rsp_way,
    output logic                  rsp_v,
    output logic                  rsp_il,
    output logic                  rsp_dl
);
    op_e              op;
    cls_e             cls;
    pol_e             pol;
    logic [IDX_W-1:0] set_idx;

    assign op      = op_e'(req_op);
    assign cls     = cls_e'(req_class);
    assign pol     = pol_e'(cfg_policy);
    assign set_idx = req_addr[OFF_W +: IDX_W];

    line_st_t         lines [WAYS];
    logic [WAY_W-1:0] rr_start;
    logic [WAYS-1:0]  locked_mask;
    logic             found;
    logic [WAY_W-1:0] pick;
    logic             want_alloc, auto_il, auto_dl;

    always_comb begin
        for (int w = 0; w < WAYS; w++)
            locked_mask[w] = lines[w].il | lines[w].dl;
    end

    lsa_alloc_ctl #(.ADDR_W(ADDR_W), .NLK(NLK)) u_alloc (
        .cls        (cls),
        .stash      (req_stash),
        .addr       (req_addr),
        .policy     (pol),
        .io_base    (cfg_io_base),
        .io_limit   (cfg_io_limit),
        .lk_en      (cfg_lk_en),
        .lk_base    (cfg_lk_base),
        .lk_limit   (cfg_lk_limit),
        .lock_all   (cfg_lock_all),
        .want_alloc (want_alloc),
        .auto_il    (auto_il),
        .auto_dl    (auto_dl)
    );

    lsa_victim_rr #(.WAYS(WAYS)) u_victim (
        .locked (locked_mask),
        .start  (rr_start),
        .found  (found),
        .pick   (pick)
    );

    logic             fill_go;
    logic [WAY_W-1:0] tgt_way;
    line_st_t         cur, base, nxt;
    logic             we, ptr_we;
    logic [WAY_W-1:0] ptr_nxt;

    assign fill_go = (op == OP_FILL) && want_alloc && found;
    assign tgt_way = (op == OP_FILL) ? pick : req_way;
    assign cur     = lines[tgt_way];
    assign ptr_nxt = WAY_W'((int'(pick) + 1) % WAYS);

    always_comb begin
        base = cur;
        if (flash_clr_ilock) base.il = 1'b0;
        if (flash_clr_dlock) base.dl = 1'b0;
        nxt    = base;
        we     = 1'b0;
        ptr_we = 1'b0;
        case (op)
            OP_FILL: begin
                if (fill_go) begin
                    nxt    = '{v: 1'b1, il: auto_il, dl: auto_dl};
                    we     = 1'b1;
                    ptr_we = 1'b1;
                end else begin
                    nxt = '0;
                end
            end
            OP_LSET, OP_LCLR: begin
                if (req_hit) begin
                    if (cls == CL_INSTR) nxt.il = (op == OP_LSET);
                    else                 nxt.dl = (op == OP_LSET);
                    we = 1'b1;
                end
            end
            default: ;
        endcase
    end

    lsa_status_mem #(.SETS(SETS), .WAYS(WAYS)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (set_idx),
        .we       (we),
        .wway     (tgt_way),
        .wdata    (nxt),
        .ptr_we   (ptr_we),
        .ptr_nxt  (ptr_nxt),
        .clr_il   (flash_clr_ilock),
        .clr_dl   (flash_clr_dlock),
        .rd_lines (lines),
        .rd_ptr   (rr_start)
    );

    line_st_t rsp_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_alloc <= 1'b0;
            rsp_way   <= '0;
            rsp_line  <= '0;
        end else begin
            rsp_valid <= is_known_op(op);
            rsp_alloc <= fill_go;
            if (op == OP_FILL)
                rsp_way <= fill_go ? pick : '0;
            else
                rsp_way <= req_way;
            if (op == OP_READ)
                rsp_line <= cur;
            else if (is_known_op(op))
                rsp_line <= nxt;
            else
                rsp_line <= '0;
        end
    end

    assign rsp_v  = rsp_line.v;
    assign rsp_il = rsp_line.il;
    assign rsp_dl = rsp_line.dl;

    // R6
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        fill_go |-> !locked_mask[pick]);

    // R7
    full_set_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_FILL) && (&locked_mask)) |=> !rsp_alloc);

    // R10
    global_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_FILL) && cfg_lock_all) |=> !rsp_alloc);

    // R4
    policy_block_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_FILL) && (cls == CL_INSTR) && (pol == POL_DATA)) |=> !rsp_alloc);

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOP) |=> !rsp_valid);

endmodule

// File: tb/test_line_status_array.sv
module test_line_status_array;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    req_op = '0;
    logic [1:0]    req_class = '0;
    logic          req_stash = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_hit = 1'b0;
    logic [1:0]    req_way = '0;
    logic [1:0]    cfg_policy = 2'd2;
    logic [AW-1:0] cfg_io_base  = 32'h1000_0000;
    logic [AW-1:0] cfg_io_limit = 32'h1000_FFFF;
    logic [1:0]    cfg_lk_en = 2'b11;
    logic [2*AW-1:0] cfg_lk_base  = {32'h3000_0000, 32'h2000_0000};
    logic [2*AW-1:0] cfg_lk_limit = {32'h3000_0FFF, 32'h2000_0FFF};
    logic          cfg_lock_all = 1'b0;
    logic          flash_clr_ilock = 1'b0;
    logic          flash_clr_dlock = 1'b0;
    logic          rsp_valid, rsp_alloc, rsp_v, rsp_il, rsp_dl;
    logic [1:0]    rsp_way;

    line_status_array i_line_status_array (
        .clk(clk), .rst(rst), .req_op(req_op), .req_class(req_class),
        .req_stash(req_stash), .req_addr(req_addr), .req_hit(req_hit),
        .req_way(req_way), .cfg_policy(cfg_policy), .cfg_io_base(cfg_io_base),
        .cfg_io_limit(cfg_io_limit), .cfg_lk_en(cfg_lk_en), .cfg_lk_base(cfg_lk_base),
        .cfg_lk_limit(cfg_lk_limit), .cfg_lock_all(cfg_lock_all),
        .flash_clr_ilock(flash_clr_ilock), .flash_clr_dlock(flash_clr_dlock),
        .rsp_valid(rsp_valid), .rsp_alloc(rsp_alloc), .rsp_way(rsp_way),
        .rsp_v(rsp_v), .rsp_il(rsp_il), .rsp_dl(rsp_dl)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // response packed as {valid, alloc, way[1:0], v, il, dl}
    task automatic chk(string tag, logic [6:0] exp);
        logic [6:0] act;
        act = {rsp_valid, rsp_alloc, rsp_way, rsp_v, rsp_il, rsp_dl};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  cls;
        logic        stash;
        logic [31:0] addr;
        logic        hit;
        logic [1:0]  way;
        logic        e_alloc;
        logic [1:0]  e_way;
        logic        e_v;
        logic        e_il;
        logic        e_dl;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{3'd2, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0}, // R6 first victim way0
        '{3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0}, // R3 R2 back-to-back read
        '{3'd2, 2'd1, 1'b0, 32'h0000_0220, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0}, // R6 way1
        '{3'd2, 2'd1, 1'b0, 32'h2000_0020, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1}, // R8 window0 data lock
        '{3'd2, 2'd0, 1'b0, 32'h3000_0020, 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0}, // R8 window1 instr lock
        '{3'd2, 2'd1, 1'b0, 32'h0000_0420, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0}, // R6 wrap to way0
        '{3'd2, 2'd2, 1'b0, 32'h5000_0020, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 outside window
        '{3'd2, 2'd2, 1'b0, 32'h1000_0020, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0}, // R5 inside window
        '{3'd2, 2'd2, 1'b1, 32'h6000_0020, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0}, // R5 stash, R6 skips locked
        '{3'd3, 2'd1, 1'b0, 32'h0000_0020, 1'b1, 2'd1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1}, // R9 set data lock
        '{3'd3, 2'd0, 1'b0, 32'h0000_0020, 1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0}, // R9 set instr lock
        '{3'd2, 2'd1, 1'b0, 32'h0000_0820, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 all locked
        '{3'd4, 2'd1, 1'b0, 32'h0000_0020, 1'b1, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0}, // R9 clear data lock
        '{3'd3, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd3, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0}, // R9 miss no effect
        '{3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd3, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0}, // R9 R3 read back unchanged
        '{3'd2, 2'd1, 1'b0, 32'h0000_0A20, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0}, // R6 only free way2
        '{3'd2, 2'd0, 1'b0, 32'h0000_0040, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0}, // R6 per-set start
        '{3'd4, 2'd0, 1'b0, 32'h0000_0020, 1'b1, 2'd3, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0}, // R9 clear instr lock
        '{3'd2, 2'd1, 1'b0, 32'h2000_0FE0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1}, // R8 near upper bound
        '{3'd2, 2'd1, 1'b0, 32'h2000_1000, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0}, // R8 just above bound
        '{3'd2, 2'd2, 1'b0, 32'h1001_0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 just above window
        '{3'd2, 2'd2, 1'b0, 32'h1000_FFE0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0}  // R5 top of window
    };

    task automatic drive(logic [2:0] op, logic [1:0] cl, logic st,
                         logic [31:0] a, logic h, logic [1:0] w);
        req_op = op; req_class = cl; req_stash = st;
        req_addr = a; req_hit = h; req_way = w;
    endtask

    task automatic issue(logic [2:0] op, logic [1:0] cl, logic st,
                         logic [31:0] a, logic h, logic [1:0] w,
                         logic fi, logic fd);
        @(negedge clk);
        drive(op, cl, st, a, h, w);
        flash_clr_ilock = fi;
        flash_clr_dlock = fd;
        @(negedge clk);
        drive(3'd0, 2'd0, 1'b0, 32'h0, 1'b0, 2'd0);
        flash_clr_ilock = 1'b0;
        flash_clr_dlock = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid low in reset", 7'b0_0_00_000);
        rst = 1'b0;
        issue(3'd1, 2'd0, 1'b0, 32'h0000_00A0, 1'b0, 2'd2, 1'b0, 1'b0);
        chk("R1 line invalid after reset", 7'b1_0_10_000);

        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0)
                chk($sformatf("table row %0d (R2 R3 R5 R6 R7 R8 R9)", i - 1),
                    {1'b1, TBL[i-1].e_alloc, TBL[i-1].e_way,
                     TBL[i-1].e_v, TBL[i-1].e_il, TBL[i-1].e_dl});
            if (i < NV)
                drive(TBL[i].op, TBL[i].cls, TBL[i].stash, TBL[i].addr,
                      TBL[i].hit, TBL[i].way);
            else
                drive(3'd0, 2'd0, 1'b0, 32'h0, 1'b0, 2'd0);
        end
        @(negedge clk);
        chk("R2 no response after idle", 7'b0_0_00_000);

        // allocation policy, set 3
        cfg_policy = 2'd0;
        issue(3'd2, 2'd1, 1'b0, 32'h0000_0060, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 data fill blocked by instr-only", 7'b1_0_00_000);
        issue(3'd2, 2'd0, 1'b0, 32'h0000_0060, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 instr fill under instr-only", 7'b1_1_00_100);
        cfg_policy = 2'd1;
        issue(3'd2, 2'd0, 1'b0, 32'h0000_0260, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 instr fill blocked by data-only", 7'b1_0_00_000);
        issue(3'd2, 2'd1, 1'b0, 32'h0000_0260, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 data fill under data-only", 7'b1_1_01_100);
        cfg_policy = 2'd3;
        issue(3'd2, 2'd1, 1'b0, 32'h0000_0460, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 no allocation policy", 7'b1_0_00_000);

        // global lock
        cfg_policy = 2'd2;
        cfg_lock_all = 1'b1;
        issue(3'd2, 2'd1, 1'b0, 32'h0000_0460, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R10 fill dropped under global lock", 7'b1_0_00_000);
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0060, 1'b0, 2'd2, 1'b0, 1'b0);
        chk("R10 way2 untouched", 7'b1_0_10_000);
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0060, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R10 way0 not replaced", 7'b1_0_00_100);
        cfg_lock_all = 1'b0;

        // flash clears on set 1: way0 il=1, way1 dl=1
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R12 read sees pre-clear instr lock", 7'b1_0_00_110);
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R11 instr lock cleared", 7'b1_0_00_100);
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd1, 1'b0, 1'b0);
        chk("R11 data lock kept by instr clear", 7'b1_0_01_101);
        issue(3'd3, 2'd1, 1'b0, 32'h0000_0020, 1'b1, 2'd0, 1'b0, 1'b1);
        chk("R12 lock-set wins over same-cycle clear", 7'b1_0_00_101);
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd1, 1'b0, 1'b0);
        chk("R11 data lock cleared", 7'b1_0_01_100);
        issue(3'd1, 2'd0, 1'b0, 32'h0000_0020, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R12 same-cycle lock survives", 7'b1_0_00_101);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule